// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds four flags that together tell firmware why the processor last left reset or sleep: a power-on flag, a brown-out flag, a watchdog time-out flag and a power-down flag. Eight single-cycle event pins report hardware happenings. Each event sets, clears or keeps each flag by its own rule. A configuration pin says whether brown-out detection is enabled. Firmware reads all four flags as one status word. It may write only the power-on and brown-out flags, which it re-arms after each reset so that it can spot the next occurrence.

There is no separate reset pin. The power-on event initializes the register through a synchronous path, so the flags are undefined until the first power-on event has been sampled. Every event and every write is sampled on the rising clock edge, and the result appears on `status_o` right after that edge. All pins are plain level signals. No data stream passes through the block, so it needs no handshake.

Top module: `rcs_status`

## Requirements
- R1: A power-on event gives POR=0, TO=1 and PD=1. BOR becomes 1 if `bor_en_i` is high and 0 if it is low, since the undefined value is modelled as 0.
- R2: A brown-out event keeps POR, clears BOR and sets TO=1 and PD=1.
- R3: A watchdog reset event gives TO=0 and PD=1 and keeps POR and BOR.
- R4: A watchdog wake-up event gives TO=0 and PD=0 and keeps POR and BOR.
- R5: A master-clear event while running keeps all four flags.
- R6: A master-clear or interrupt wake-up during sleep gives TO=1 and PD=0 and keeps POR and BOR.
- R7: The sleep instruction event gives TO=1 and PD=0. The clear-watchdog instruction event gives TO=1 and PD=1. Both keep POR and BOR.
- R8: When several events are high in one cycle, only one of them applies. The order from highest to lowest is: power-on, brown-out, watchdog reset, sleep wake, watchdog wake, master-clear while running, sleep instruction, clear-watchdog instruction.
- R9: With no event high, a write loads POR from `wr_data_i[1]` and BOR from `wr_data_i[0]`. The TO and PD flags and the other data bits are ignored.
- R10: A write in a cycle where any event is high is dropped entirely, even if that event keeps the flags unchanged.
- R11: With no event and no write, all flags stay unchanged.
- R12: `status_o` carries BOR at bit 0, POR at bit 1, PD at bit 2 and TO at bit 3, and all higher bits read 0. Each change is visible right after the clock edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_on_i | input | 1 | Power-on reset event |
| brown_out_i | input | 1 | Brown-out reset event |
| wdt_rst_i | input | 1 | Watchdog reset while running |
| wdt_wake_i | input | 1 | Watchdog wake-up from sleep |
| mclr_run_i | input | 1 | Master-clear reset while running |
| sleep_wake_i | input | 1 | Master-clear or interrupt wake-up during sleep |
| sleep_op_i | input | 1 | Sleep instruction executed |
| clrwdt_op_i | input | 1 | Clear-watchdog instruction executed |
| bor_en_i | input | 1 | Brown-out detection enabled |
| wr_en_i | input | 1 | Firmware write strobe |
| wr_data_i | input | REG_W | Firmware write data |
| status_o | output | REG_W | Flag word as seen by firmware |

## Verification
The bench builds the block with its default 8-bit status word and with BOR modelled as 0 after a power-on reset when detection is off. Because there are only eight event pins, the bench can sweep all 256 event combinations. It repeats the sweep for both brown-out enable settings, with and without a simultaneous write, and from four different starting flag patterns. This reaches every priority conflict, every hold rule and every write collision.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int N_EVT   = 8;
  localparam int BOR_BIT = 0;
  localparam int POR_BIT = 1;
  localparam int PD_BIT  = 2;
  localparam int TO_BIT  = 3;
  localparam int N_FLAG  = 4;

  typedef struct packed {
    logic to;
    logic pd;
    logic por;
    logic bor;
  } rcs_flags_t;

  // Index into the priority-ordered request vector is cause value minus one.
  typedef enum logic [3:0] {
    C_NONE      = 4'd0,
    C_PWR       = 4'd1,
    C_BROWN     = 4'd2,
    C_WDT_RST   = 4'd3,
    C_SLP_WAKE  = 4'd4,
    C_WDT_WAKE  = 4'd5,
    C_MCLR_RUN  = 4'd6,
    C_SLEEP     = 4'd7,
    C_CLRWDT    = 4'd8
  } cause_e;
endpackage

// File: rtl/rcs_evt_arb.sv
module rcs_evt_arb
  import rcs_pkg::*;
#(
  parameter int N_SRC = N_EVT
) (
  input  logic [N_SRC-1:0] req_i,
  output cause_e           cause_o,
  output logic             any_o
);
  // Lowest index has the highest priority; it is assigned last.
  always_comb begin
    cause_o = C_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) cause_o = cause_e'(4'(i + 1));
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rcs_flag_next.sv
module rcs_flag_next
  import rcs_pkg::*;
#(
  parameter logic BOR_UNDEF_VAL = 1'b0
) (
  input  cause_e     cause_i,
  input  logic       bor_en_i,
  input  rcs_flags_t cur_i,
  output rcs_flags_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (cause_i)
      C_PWR: begin
        nxt_o.por = 1'b0;
        nxt_o.bor = bor_en_i ? 1'b1 : BOR_UNDEF_VAL;
        nxt_o.to  = 1'b1;
        nxt_o.pd  = 1'b1;
      end
      C_BROWN: begin
        nxt_o.bor = 1'b0;
        nxt_o.to  = 1'b1;
        nxt_o.pd  = 1'b1;
      end
      C_WDT_RST:  begin nxt_o.to = 1'b0; nxt_o.pd = 1'b1; end
      C_WDT_WAKE: begin nxt_o.to = 1'b0; nxt_o.pd = 1'b0; end
      C_SLP_WAKE: begin nxt_o.to = 1'b1; nxt_o.pd = 1'b0; end
      C_SLEEP:    begin nxt_o.to = 1'b1; nxt_o.pd = 1'b0; end
      C_CLRWDT:   begin nxt_o.to = 1'b1; nxt_o.pd = 1'b1; end
      default:    nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/rcs_reg_view.sv
module rcs_reg_view
  import rcs_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  rcs_flags_t       flags_i,
  output logic [REG_W-1:0] word_o
);
  localparam int PAD_W = REG_W - N_FLAG;

  always_comb begin
    word_o          = '0;
    word_o[BOR_BIT] = flags_i.bor;
    word_o[POR_BIT] = flags_i.por;
    word_o[PD_BIT]  = flags_i.pd;
    word_o[TO_BIT]  = flags_i.to;
  end

  initial begin
    if (PAD_W < 0) $error("REG_W must hold all four flags");
  end
endmodule

// File: rtl/rcs_status.sv
module rcs_status
  import rcs_pkg::*;
#(
  parameter int   REG_W         = 8,
  parameter logic BOR_UNDEF_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             pwr_on_i,
  input  logic             brown_out_i,
  input  logic             wdt_rst_i,
  input  logic             wdt_wake_i,
  input  logic             mclr_run_i,
  input  logic             sleep_wake_i,
  input  logic             sleep_op_i,
  input  logic             clrwdt_op_i,
  input  logic             bor_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] status_o
);
  logic [N_EVT-1:0] req;
  cause_e           cause;
  logic             any_evt;
  rcs_flags_t       q, hw_nxt, d;
  logic             unused_wr_bits;

  // Priority order: index 0 wins.
  assign req = {clrwdt_op_i, sleep_op_i, mclr_run_i, wdt_wake_i,
                sleep_wake_i, wdt_rst_i, brown_out_i, pwr_on_i};

  rcs_evt_arb #(.N_SRC(N_EVT)) u_arb (
    .req_i   (req),
    .cause_o (cause),
    .any_o   (any_evt)
  );

  rcs_flag_next #(.BOR_UNDEF_VAL(BOR_UNDEF_VAL)) u_next (
    .cause_i  (cause),
    .bor_en_i (bor_en_i),
    .cur_i    (q),
    .nxt_o    (hw_nxt)
  );

  // Hardware events override firmware writes completely.
  always_comb begin
    d = q;
    if (any_evt) begin
      d = hw_nxt;
    end else if (wr_en_i) begin
      d.por = wr_data_i[POR_BIT];
      d.bor = wr_data_i[BOR_BIT];
    end
  end

  always_ff @(posedge clk_i) q <= d;

  rcs_reg_view #(.REG_W(REG_W)) u_view (
    .flags_i (q),
    .word_o  (status_o)
  );

  assign unused_wr_bits = ^{wr_data_i[REG_W-1:PD_BIT]};

  p_pwr_on_r1: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(pwr_on_i) |->
      (!q.por && q.to && q.pd && q.bor == ($past(bor_en_i) ? 1'b1 : BOR_UNDEF_VAL)));

  p_brown_r2: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(brown_out_i && !pwr_on_i) |->
      (!q.bor && q.to && q.pd && q.por == $past(q.por)));

  p_wdt_rst_r3: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(wdt_rst_i && !pwr_on_i && !brown_out_i) |-> (!q.to && q.pd));

  p_wdt_wake_r4: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(wdt_wake_i && !pwr_on_i && !brown_out_i && !wdt_rst_i && !sleep_wake_i)
      |-> (!q.to && !q.pd));

  p_fw_write_r9: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(wr_en_i && !any_evt && !pwr_on_i) |->
      (q.por == $past(wr_data_i[POR_BIT]) && q.bor == $past(wr_data_i[BOR_BIT])
       && q.to == $past(q.to) && q.pd == $past(q.pd)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $past(!any_evt && !wr_en_i && !pwr_on_i) |-> $stable(status_o));
endmodule

// File: tb/test_rcs_status.sv
`timescale 1ns/1ps
module test_rcs_status;
  localparam int REG_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]       ev;
  logic             bor_en, wr_en;
  logic [REG_W-1:0] wr_data, status;
  int checks = 0, errors = 0;
  bit done = 0;

  rcs_status #(.REG_W(REG_W), .BOR_UNDEF_VAL(1'b0)) i_rcs_status (
    .clk_i(clk), .pwr_on_i(ev[0]), .brown_out_i(ev[1]), .wdt_rst_i(ev[2]),
    .sleep_wake_i(ev[3]), .wdt_wake_i(ev[4]), .mclr_run_i(ev[5]),
    .sleep_op_i(ev[6]), .clrwdt_op_i(ev[7]), .bor_en_i(bor_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .status_o(status)
  );

  // Word layout per R12: {TO,PD,POR,BOR} in bits 3..0.
  function automatic logic [REG_W-1:0] pack(logic t, logic p, logic o, logic b);
    return {{(REG_W-4){1'b0}}, t, p, o, b};
  endfunction

  function automatic logic [REG_W-1:0] model(logic [7:0] e, logic be, logic we,
                                             logic [REG_W-1:0] wd, logic [REG_W-1:0] cur);
    logic t = cur[3], p = cur[2], o = cur[1], b = cur[0];
    if (e == 8'd0) begin
      if (we) begin o = wd[1]; b = wd[0]; end
    end
    else if (e[0]) begin o = 0; b = be; t = 1; p = 1; end
    else if (e[1]) begin b = 0; t = 1; p = 1; end
    else if (e[2]) begin t = 0; p = 1; end
    else if (e[3]) begin t = 1; p = 0; end
    else if (e[4]) begin t = 0; p = 0; end
    else if (e[5]) begin end
    else if (e[6]) begin t = 1; p = 0; end
    else begin t = 1; p = 1; end
    return pack(t, p, o, b);
  endfunction

  function automatic string tag(logic [7:0] e, logic we);
    if (e == 0) return we ? "R9" : "R11";
    if (e[0]) return "R1";
    if (e[1]) return "R2";
    if (e[2]) return "R3";
    if (e[3]) return "R6";
    if (e[4]) return "R4";
    if (e[5]) return we ? "R10" : "R5";
    return "R7";
  endfunction

  task automatic apply(logic [7:0] e, logic be, logic we, logic [REG_W-1:0] wd);
    ev = e; bor_en = be; wr_en = we; wr_data = wd;
    @(negedge clk);
    ev = 0; wr_en = 0;
  endtask

  task automatic check(string rq, logic [REG_W-1:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", rq, status, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] cur, exp, wd;
    ev = 0; bor_en = 1; wr_en = 0; wr_data = 0;
    @(negedge clk);
    apply(8'h01, 1'b1, 1'b0, '0);
    check("R1", pack(1, 1, 0, 1));
    apply(8'h01, 1'b0, 1'b0, '0);
    check("R1", pack(1, 1, 0, 0));
    // R12: high write bits and TO/PD write bits never reach the word
    apply(8'h00, 1'b0, 1'b1, 8'hFF);
    check("R12", pack(1, 1, 1, 1));

    for (int s = 0; s < 4; s++) begin
      for (int be = 0; be < 2; be++) begin
        for (int we = 0; we < 2; we++) begin
          for (int e = 0; e < 256; e++) begin
            // Preset TO/PD through an event, POR/BOR through a write
            case (s)
              0: apply(8'h10, 1'b1, 1'b0, '0);
              1: apply(8'h04, 1'b1, 1'b0, '0);
              2: apply(8'h40, 1'b1, 1'b0, '0);
              default: apply(8'h80, 1'b1, 1'b0, '0);
            endcase
            apply(8'h00, 1'b1, 1'b1, 8'(s ^ (e >> 3)));
            cur = status;
            wd = 8'(e * 37 + s);
            exp = model(8'(e), 1'(be), 1'(we), wd, cur);
            apply(8'(e), 1'(be), 1'(we), wd);
            check(tag(8'(e), 1'(we)), exp);
          end
        end
      end
    end

    // R8: two-event conflicts spelled out
    apply(8'h00, 1'b1, 1'b1, 8'h03);
    apply(8'h06, 1'b1, 1'b0, '0);
    check("R8", pack(1, 1, 1, 0));
    apply(8'h30, 1'b1, 1'b0, '0);
    check("R8", pack(0, 0, 1, 0));
    apply(8'hC0, 1'b1, 1'b0, '0);
    check("R8", pack(1, 0, 1, 0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule